// File: doc/BRIEF.md
# Datapath Function Unit (ALU plus Single-Step Shifter)

This block is the purely combinational function unit of a small register-file datapath. It takes two operands of a parameterised width and a 4-bit function code. It returns one result word and four status flags: overflow (V), carry (C), negative (N) and zero (Z). There are three sections inside it. The arithmetic section is an adder whose second input passes through conditioning logic first. The bitwise logic section works on the operands. The shifter moves the second operand by one place.

The function code drives the internal selects directly, with no decoding table. Bit 3 is the mode, bits 2 and 1 condition the second adder input, and bit 0 is the carry-in. The two low bits also pick the logic operation and the shift direction. When bits 3 and 2 are both set, the shifter drives the result instead of the ALU. A sequencer places this unit between the register-file read buses and the write-back mux, and it produces a result in the same cycle.

Top module: `fu_func_unit`

## Requirements
- R1: When code bit 3 is 0, the result is A + Y + code[0] modulo 2^W. Y is set by code[2:1]: 00 gives zero, 01 gives B, 10 gives ~B and 11 gives all ones. Codes 0000 and 0111 therefore both return A, and code 0101 returns A − B.
- R2: Code 0010 returns A + B, and code 0110 returns A − 1, both modulo 2^W.
- R3: Codes 10xx select bitwise logic: 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B and 1011 gives NOT A.
- R4: Code 1100 returns B unchanged. Code 1101 returns B shifted right one place, and code 1110 returns B shifted left one place. The vacated bit is filled with 0 in both shifts.
- R5: Code 1111 returns all zeros.
- R6: For arithmetic codes, C equals the carry out of the most significant adder bit.
- R7: For arithmetic codes, V equals the carry into the most significant bit XOR the carry out of it. This is the two's-complement overflow of A + Y + cin.
- R8: For every code with bit 3 set (logic and shift), C and V are both 0.
- R9: N equals the most significant bit of the result for every code.
- R10: Z is 1 exactly when every result bit is 0, for every code.
- R11: The operand width is a parameter W (default 8, minimum 2), and R1–R10 hold for any such width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | Operand A (adder and logic input) |
| op_b | input | W | Operand B (conditioned adder input, logic input, shifter input) |
| fn_code | input | 4 | Function code {mode, sel1, sel0, cin} |
| res_f | output | W | Result word |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Negative (result MSB) |
| flag_z | output | 1 | Zero result |

## Verification
The bench builds two copies of the unit, one at the default width of 8 and one with W = 4. The narrow copy keeps the input space small, so every function code is applied with every pair of operands. That reaches every carry and overflow combination and every shift edge bit exhaustively. The 8-bit copy takes fixed corner values (sums that wrap, 0x7F + 1, A − 1 at zero) and a random sweep of all sixteen codes. Both copies are compared against a model written from the requirements.

// File: rtl/fu_pkg.sv
// Shared definitions for the datapath function unit.
// Assumes the function code is always 4 bits wide: {mode, sel1, sel0, cin}.
package fu_pkg;
    localparam int CODE_W = 4;

    typedef struct packed {
        logic mode;  // 0 = arithmetic, 1 = logic / shift
        logic sel1;  // adder conditioning select, high bit
        logic sel0;  // adder conditioning select, low bit / op select high
        logic cin;   // carry-in / op select low
    } fn_code_t;

    // Shifter control taken from the low code bits.
    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_ZERO  = 2'b11
    } shift_op_e;
endpackage

// File: rtl/fu_arith.sv
// Arithmetic section: an adder with conditioning on its B input.
// Computes A + Y + cin, where Y is one of 0, B, ~B or all ones.
// Assumes W >= 2 so that the carry into the MSB can be separated out.
module fu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel1,
    input  logic         sel0,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int LOW_W = W - 1;

    logic [W-1:0]   y_in;
    logic [LOW_W:0] low_sum;
    logic           top_sum;
    logic           carry_msb;

    // Condition B: pass B when sel0 is set, pass ~B when sel1 is set.
    always_comb begin
        y_in = ({W{sel0}} & b) | ({W{sel1}} & ~b);
    end

    // Add the lower bits first, so that the carry into the MSB is visible.
    always_comb begin
        low_sum   = {1'b0, a[LOW_W-1:0]} + {1'b0, y_in[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
        carry_msb = low_sum[LOW_W];
        {cout, top_sum} = {1'b0, a[W-1]} + {1'b0, y_in[W-1]} + {1'b0, carry_msb};
        sum       = {top_sum, low_sum[LOW_W-1:0]};
        ovf       = carry_msb ^ cout;
    end
endmodule

// File: rtl/fu_logic.sv
// Bitwise logic section: AND, OR, XOR of A and B, or NOT A.
// The operation is picked by {sel0, cin} of the function code.
module fu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W-1:0] y
);
    // Pick one bitwise operation per op value.
    always_comb begin
        unique case (op)
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = a ^ b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/fu_shift.sv
// One-place shifter acting on B: pass, right, left, or zero.
// Vacated bit positions are filled with 0. The code 11 output is zero.
module fu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0]       b,
    input  fu_pkg::shift_op_e  op,
    output logic [W-1:0]       y
);
    // Select the shifted or passed form of B.
    always_comb begin
        unique case (op)
            fu_pkg::SH_PASS:  y = b;
            fu_pkg::SH_RIGHT: y = {1'b0, b[W-1:1]};
            fu_pkg::SH_LEFT:  y = {b[W-2:0], 1'b0};
            default:          y = '0;
        endcase
    end
endmodule

// File: rtl/fu_func_unit.sv
// Function unit top: arithmetic, logic and shifter sections behind a
// result mux, plus V/C/N/Z status generation. Purely combinational.
// Assumes W >= 2. The code bits feed the section selects directly.
module fu_func_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   fn_code,
    output logic [W-1:0] res_f,
    output logic         flag_v,
    output logic         flag_c,
    output logic         flag_n,
    output logic         flag_z
);
    import fu_pkg::*;

    fn_code_t        code;
    logic [W-1:0]    arith_y;
    logic [W-1:0]    logic_y;
    logic [W-1:0]    shift_y;
    logic [W-1:0]    alu_y;
    logic            arith_c;
    logic            arith_v;
    logic            pick_shift;
    shift_op_e       sh_op;

    // Split the raw code into its named select fields.
    always_comb begin
        code  = fn_code_t'(fn_code);
        sh_op = shift_op_e'({code.sel0, code.cin});
    end

    fu_arith #(.W(W)) u_arith (
        .a    (op_a),
        .b    (op_b),
        .sel1 (code.sel1),
        .sel0 (code.sel0),
        .cin  (code.cin),
        .sum  (arith_y),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    fu_logic #(.W(W)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .op ({code.sel0, code.cin}),
        .y  (logic_y)
    );

    fu_shift #(.W(W)) u_shift (
        .b  (op_b),
        .op (sh_op),
        .y  (shift_y)
    );

    // Route the selected section to the result and form the flags.
    always_comb begin
        pick_shift = code.mode & code.sel1;
        alu_y      = code.mode ? logic_y : arith_y;
        res_f      = pick_shift ? shift_y : alu_y;
        flag_c     = ~code.mode & arith_c;
        flag_v     = ~code.mode & arith_v;
        flag_n     = res_f[W-1];
        flag_z     = ~|res_f;
    end
endmodule

// File: rtl/fu_func_unit_chk.sv
// Checker for the function unit. It relates the ports for selected codes.
// Attached to every instance of the top module through a bind.
module fu_func_unit_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [3:0]   fn_code,
    input logic [W-1:0] res_f,
    input logic         flag_v,
    input logic         flag_c,
    input logic         flag_n,
    input logic         flag_z
);
    // Check port relations whenever any port changes.
    always_comb begin
        if (fn_code == 4'b0000 || fn_code == 4'b0111)
            AST_ARITH_IDENT: assert (res_f == op_a && flag_v == 1'b0); // R1
        if (fn_code == 4'b0101 && op_a == op_b)
            AST_SUB_EQUAL: assert (flag_z && flag_c); // R1
        if (fn_code == 4'b0010)
            AST_ADD_SUM: assert ({flag_c, res_f} == {1'b0, op_a} + {1'b0, op_b}); // R2
        if (fn_code == 4'b1100)
            AST_SHIFT_PASS: assert (res_f == op_b); // R4
        if (fn_code == 4'b1111)
            AST_CODE_ZERO: assert (flag_z && !flag_n); // R5
        if (fn_code[3])
            AST_NO_CARRY_OVF: assert (!flag_c && !flag_v); // R8
        if (flag_z)
            AST_ZERO_NOT_NEG: assert (!flag_n); // R10
    end
endmodule

bind fu_func_unit fu_func_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_fu_func_unit.sv
// Scoreboard bench: the driver pushes expected items, the monitor compares.
module tb_fu_func_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] a8, b8, f8;
    logic [3:0] a4, b4, f4;
    logic [3:0] c8, c4;
    logic v8, cy8, n8, z8, v4, cy4, n4, z4;

    fu_func_unit dut (
        .op_a(a8), .op_b(b8), .fn_code(c8), .res_f(f8),
        .flag_v(v8), .flag_c(cy8), .flag_n(n8), .flag_z(z8));

    fu_func_unit #(.W(4)) dut_w4 (
        .op_a(a4), .op_b(b4), .fn_code(c4), .res_f(f4),
        .flag_v(v4), .flag_c(cy4), .flag_n(n4), .flag_z(z4));

    typedef struct {
        int w;
        logic [3:0] code;
        int f, v, c;
    } item_t;

    item_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void model(input int w, input logic [3:0] code,
                                  input int a, input int b,
                                  output int f, output int v, output int c);
        int mask, y, s;
        mask = (1 << w) - 1;
        v = 0; c = 0;
        if (!code[3]) begin
            case (code[2:1])
                2'b00: y = 0;
                2'b01: y = b;
                2'b10: y = ~b & mask;
                default: y = mask;
            endcase
            s = a + y + int'(code[0]);
            f = s & mask;
            c = (s >> w) & 1;
            v = (((a >> (w-1)) & 1) == ((y >> (w-1)) & 1) &&
                 ((f >> (w-1)) & 1) != ((a >> (w-1)) & 1)) ? 1 : 0;
        end else if (!code[2]) begin
            case (code[1:0])
                2'b00: f = a & b;
                2'b01: f = a | b;
                2'b10: f = a ^ b;
                default: f = ~a & mask;
            endcase
        end else begin
            case (code[1:0])
                2'b00: f = b;
                2'b01: f = b >> 1;
                2'b10: f = (b << 1) & mask;
                default: f = 0;
            endcase
        end
    endfunction

    // Driver: apply one vector at a clock edge and queue what it must give.
    task automatic drive(int w, logic [3:0] code, int a, int b);
        item_t it;
        @(posedge clk);
        if (w == 8) begin a8 = a[7:0]; b8 = b[7:0]; c8 = code; end
        else        begin a4 = a[3:0]; b4 = b[3:0]; c4 = code; end
        it.w = w; it.code = code;
        model(w, code, a, b, it.f, it.v, it.c);
        sb_q.push_back(it);
    endtask

    // Monitor: compare each queued item at the following falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                string rf;
                int af, av, ac, an, az;
                it = sb_q.pop_front();
                if (it.w == 8) begin af = int'(f8); av = int'(v8); ac = int'(cy8); an = int'(n8); az = int'(z8); end
                else           begin af = int'(f4); av = int'(v4); ac = int'(cy4); an = int'(n4); az = int'(z4); end
                if (it.w == 4)                                   rf = "R11";
                else if (it.code == 4'b0010 || it.code == 4'b0110) rf = "R2";
                else if (!it.code[3])                            rf = "R1";
                else if (!it.code[2])                            rf = "R3";
                else if (it.code == 4'b1111)                     rf = "R5";
                else                                             rf = "R4";
                chk(rf, af, it.f);
                chk(it.code[3] ? "R8" : "R6", ac, it.c);
                chk(it.code[3] ? "R8" : "R7", av, it.v);
                chk("R9", an, (it.f >> (it.w - 1)) & 1);
                chk("R10", az, (it.f == 0) ? 1 : 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Stimulus: directed corners, random 8-bit sweep, exhaustive 4-bit sweep.
    initial begin
        a8 = '0; b8 = '0; c8 = '0; a4 = '0; b4 = '0; c4 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(8, 4'b0000, 0, 0);          // state after reset: F=0, Z=1
        drive(8, 4'b0010, 8'h05, 8'h03);  // R2 add
        drive(8, 4'b0010, 8'h07, 8'h1C);  // R2 add
        drive(8, 4'b0010, 8'h7F, 8'h01);  // R7 overflow
        drive(8, 4'b0010, 8'hFF, 8'h01);  // R6 carry, R10 zero
        drive(8, 4'b0110, 8'h00, 8'h55);  // R2 A-1 at zero
        drive(8, 4'b0101, 8'h80, 8'h01);  // R7 subtract overflow
        drive(8, 4'b0111, 8'hA5, 8'h00);  // R1 identity
        drive(8, 4'b1101, 8'h00, 8'h81);  // R4 right, zero fill
        drive(8, 4'b1110, 8'h00, 8'h81);  // R4 left, zero fill
        drive(8, 4'b1111, 8'hFF, 8'hFF);  // R5
        drive(8, 4'b1011, 8'hFF, 8'h00);  // R3 NOT
        for (int k = 0; k < 40; k++)
            for (int cd = 0; cd < 16; cd++)
                drive(8, cd[3:0], int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
        for (int cd = 0; cd < 16; cd++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    drive(4, cd[3:0], a, b);
        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule